// File: doc/BRIEF.md
# Audio Interrupt Status Aggregator

This block keeps the interrupt status word for a three-channel audio engine and drives the engine's level-sensitive interrupt line. The channels are two playback channels and one record channel. Each channel raises a one-cycle pulse when its sample counter runs out. The pulse leaves a sticky pending flag in the status word, but only if that channel's interrupt enable bit in the serial-control register is set at the time of the pulse.

Software cannot clear a pending flag by writing the status word. The only way to clear a flag is to withdraw the matching enable. When a serial-control write turns an enable bit from 1 to 0, the flag for that channel is cleared on the same clock edge. The summary bit and the interrupt line are recomputed from the channel flags on every update.

The status word also carries a fixed two-bit source field that reads 3. It keeps UART and voice positions that always read zero and never take part in the summary. The block sits beside the serial-control register. It sees the register's current value and, on each write, the incoming value.

Top module: `aud_irq_agg`

## Requirements
- R1: After reset, `statusOut` is 0x00000060 and `irqOut` is 0.
- R2: A pulse on `expiredPulse[i]` while the current enable `sctlCur[8+i]` is 1 sets that channel's pending bit on the next clock edge. Channel 0 (playback 1) maps to status bit 2, channel 1 (playback 2) to bit 1, and channel 2 (record) to bit 0.
- R3: A pulse on `expiredPulse[i]` while `sctlCur[8+i]` is 0 leaves the status word unchanged.
- R4: A write with `sctlWrEn`=1, where `sctlCur[8+i]`=1 and `sctlWrData[8+i]`=0, clears channel i's pending bit on the next edge.
- R5: A write that keeps an enable at 1, keeps it at 0, or raises it from 0 to 1 leaves that channel's pending bit unchanged.
- R6: When a channel's pulse and the 1-to-0 write of its enable arrive in the same cycle, the pending bit ends up cleared.
- R7: Status bit 31 is the OR of status bits 2:0. Bits 3 and 4 read 0 and never affect bit 31.
- R8: `irqOut` equals the OR of the three pending bits and changes on the same edge as `statusOut`.
- R9: Status bits 6:5 always read 3, and every status bit not named in R2, R7 or R9 reads 0.
- R10: A pending bit stays set until it is cleared as described in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| expiredPulse | input | 3 | Per-channel sample-count-expired pulse (0 = playback 1, 1 = playback 2, 2 = record) |
| sctlCur | input | 32 | Current serial-control value; bits 10:8 are the channel interrupt enables |
| sctlWrEn | input | 1 | A serial-control write happens this cycle |
| sctlWrData | input | 32 | Value being written to serial control |
| statusOut | output | 32 | Status word |
| irqOut | output | 1 | Level interrupt line |

## Verification
The bench builds the block with its default parameters: three channels, a 32-bit word, enables starting at bit 8, and the source field at bits 6:5 holding 3. With these values the real bit positions are checked directly, including the reversed order between the enable bits and the status bits. A table of vectors drives mixtures of enable levels, writes and pulses. These include every kind of enable transition and a pulse that collides with a falling enable. The pending state is carried from one vector to the next, so stickiness is exercised throughout. Directed tests then cover a reset taken while flags are pending.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;
  // Channel count of the audio engine: playback 1, playback 2, record
  localparam int CHAN_COUNT = 3;

  // Strobes from control to datapath, one bit per channel
  typedef struct packed {
    logic [CHAN_COUNT-1:0] setReq;
    logic [CHAN_COUNT-1:0] clrReq;
  } irqStrobes_t;
endpackage

// File: rtl/aud_irq_ctrl.sv
module aud_irq_ctrl
  import aud_irq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int EN_BASE = 8
) (
  input  logic [CHAN_COUNT-1:0] expiredPulse,
  input  logic [DATA_W-1:0]     sctlCur,
  input  logic                  sctlWrEn,
  input  logic [DATA_W-1:0]     sctlWrData,
  output irqStrobes_t           strobes
);
  logic [CHAN_COUNT-1:0] enOld;
  logic [CHAN_COUNT-1:0] enNew;

  assign enOld = sctlCur[EN_BASE +: CHAN_COUNT];
  assign enNew = sctlWrData[EN_BASE +: CHAN_COUNT];

  always_comb begin
    strobes = '0;
    for (int i = 0; i < CHAN_COUNT; i++) begin
      // A pulse is seen only while the enable already stands at 1
      strobes.setReq[i] = expiredPulse[i] && enOld[i];
      // Only a falling enable within a write clears
      strobes.clrReq[i] = sctlWrEn && enOld[i] && !enNew[i];
    end
  end
endmodule

// File: rtl/aud_irq_dp.sv
module aud_irq_dp
  import aud_irq_pkg::*;
#(
  parameter int              DATA_W  = 32,
  parameter int              SRC_LSB = 5,
  parameter int              SRC_W   = 2,
  parameter logic [SRC_W-1:0] SRC_VAL = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  irqStrobes_t       strobes,
  output logic [DATA_W-1:0] statusOut,
  output logic              irqOut
);
  localparam int SUM_POS = DATA_W - 1;

  logic [CHAN_COUNT-1:0] pendQ;
  logic [CHAN_COUNT-1:0] pendNext;
  logic                  irqQ;

  // The clear takes priority over a set in the same cycle
  assign pendNext = (pendQ | strobes.setReq) & ~strobes.clrReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
      irqQ  <= 1'b0;
    end else begin
      pendQ <= pendNext;
      irqQ  <= |pendNext;
    end
  end

  // Channel i is placed at status bit CHAN_COUNT-1-i
  always_comb begin
    statusOut = '0;
    for (int i = 0; i < CHAN_COUNT; i++) begin
      statusOut[CHAN_COUNT-1-i] = pendQ[i];
    end
    statusOut[SRC_LSB +: SRC_W] = SRC_VAL;
    statusOut[SUM_POS]          = |pendQ;
  end

  assign irqOut = irqQ;

  // R8: the registered line tracks the pending flags
  p_irq_match_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == statusOut[SUM_POS]);

  // R9: fixed source field
  p_src_fixed_r9: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[SRC_LSB +: SRC_W] == SRC_VAL);

  generate
    for (genvar g = 0; g < CHAN_COUNT; g++) begin : gChk
      // R10: flags are sticky without a clear strobe
      p_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
        pendQ[g] && !strobes.clrReq[g] |=> pendQ[g]);
      // R6: a clear strobe always leaves the flag low
      p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
        strobes.clrReq[g] |=> !pendQ[g]);
    end
  endgenerate
endmodule

// File: rtl/aud_irq_agg.sv
module aud_irq_agg
  import aud_irq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int EN_BASE = 8,
  parameter int SRC_LSB = 5,
  parameter int SRC_W   = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [CHAN_COUNT-1:0] expiredPulse,
  input  logic [DATA_W-1:0]     sctlCur,
  input  logic                  sctlWrEn,
  input  logic [DATA_W-1:0]     sctlWrData,
  output logic [DATA_W-1:0]     statusOut,
  output logic                  irqOut
);
  irqStrobes_t strobes;

  aud_irq_ctrl #(
    .DATA_W (DATA_W),
    .EN_BASE(EN_BASE)
  ) u_ctrl (
    .expiredPulse(expiredPulse),
    .sctlCur     (sctlCur),
    .sctlWrEn    (sctlWrEn),
    .sctlWrData  (sctlWrData),
    .strobes     (strobes)
  );

  aud_irq_dp #(
    .DATA_W (DATA_W),
    .SRC_LSB(SRC_LSB),
    .SRC_W  (SRC_W),
    .SRC_VAL('1)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .statusOut(statusOut),
    .irqOut   (irqOut)
  );

  generate
    for (genvar g = 0; g < CHAN_COUNT; g++) begin : gPortChk
      // R2: an enabled pulse without a falling write sets the flag
      p_set_r2: assert property (@(posedge clk) disable iff (!rstN)
        expiredPulse[g] && sctlCur[EN_BASE+g]
        && !(sctlWrEn && !sctlWrData[EN_BASE+g])
        |=> statusOut[CHAN_COUNT-1-g]);
      // R3: with the enable low a clear flag stays clear
      p_ignore_r3: assert property (@(posedge clk) disable iff (!rstN)
        !sctlCur[EN_BASE+g] && !statusOut[CHAN_COUNT-1-g]
        |=> !statusOut[CHAN_COUNT-1-g]);
      // R4: a falling enable clears the flag
      p_fall_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
        sctlWrEn && sctlCur[EN_BASE+g] && !sctlWrData[EN_BASE+g]
        |=> !statusOut[CHAN_COUNT-1-g]);
    end
  endgenerate
endmodule

// File: tb/aud_irq_agg_bench.sv
`timescale 1ns/1ps
module aud_irq_agg_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  expiredPulse = '0;
  logic [31:0] sctlCur = '0;
  logic        sctlWrEn = 1'b0;
  logic [31:0] sctlWrData = '0;
  logic [31:0] statusOut;
  logic        irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  aud_irq_agg u_aud_irq_agg (
    .clk(clk), .rstN(rstN), .expiredPulse(expiredPulse),
    .sctlCur(sctlCur), .sctlWrEn(sctlWrEn), .sctlWrData(sctlWrData),
    .statusOut(statusOut), .irqOut(irqOut)
  );

  // Vector: {enCur[2:0], wr, enNew[2:0], pulse[2:0], expStat[2:0]}
  // enCur/enNew/pulse are {record, pb2, pb1}; expStat is status bits {2,1,0} = {pb1, pb2, record}
  localparam int NV = 12;
  localparam logic [12:0] VEC [NV] = '{
    {3'b001, 1'b0, 3'b000, 3'b001, 3'b100}, // R2 pb1 -> bit2
    {3'b000, 1'b0, 3'b000, 3'b110, 3'b100}, // R3 disabled pulses, R10 hold
    {3'b111, 1'b0, 3'b000, 3'b110, 3'b111}, // R2 pb2, record
    {3'b111, 1'b1, 3'b111, 3'b000, 3'b111}, // R5 1->1
    {3'b111, 1'b1, 3'b110, 3'b000, 3'b011}, // R4 pb1 falls
    {3'b110, 1'b1, 3'b111, 3'b000, 3'b011}, // R5 0->1
    {3'b111, 1'b1, 3'b011, 3'b100, 3'b010}, // R6 record pulse vs fall
    {3'b011, 1'b1, 3'b001, 3'b001, 3'b100}, // R4 pb2 falls, R2 pb1 set
    {3'b001, 1'b1, 3'b000, 3'b000, 3'b000}, // R4 pb1 falls, R8 irq low
    {3'b000, 1'b1, 3'b000, 3'b000, 3'b000}, // R5 0->0
    {3'b100, 1'b0, 3'b000, 3'b100, 3'b001}, // R2 record -> bit0
    {3'b100, 1'b1, 3'b100, 3'b000, 3'b001}  // R5 record 1->1
  };

  function automatic logic [31:0] fullStatus(input logic [2:0] s);
    return 32'h0000_0060 | {29'd0, s} | ((s != 3'b000) ? 32'h8000_0000 : 32'h0);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 status", statusOut, 32'h0000_0060);
    check("R1 irq", {31'd0, irqOut}, 32'd0);
    rstN = 1'b1;
    @(posedge clk); #1;
    check("R9 idle status", statusOut, 32'h0000_0060);

    for (int v = 0; v < NV; v++) begin
      logic [12:0] e;
      e = VEC[v];
      // unrelated bits in serial control must have no effect
      sctlCur      = 32'h0000_00F3 | ({29'd0, e[12:10]} << 8);
      sctlWrEn     = e[9];
      sctlWrData   = 32'h0000_00AC | ({29'd0, e[8:6]} << 8);
      expiredPulse = e[5:3];
      @(posedge clk); #1;
      sctlWrEn = 1'b0;
      expiredPulse = '0;
      check($sformatf("R2-R7 vec %0d status", v), statusOut, fullStatus(e[2:0]));
      check($sformatf("R8 vec %0d irq", v), {31'd0, irqOut}, {31'd0, e[2:0] != 3'b000});
    end

    // R10: an idle cycle keeps the record flag
    sctlCur = 32'h0;
    @(posedge clk); #1;
    check("R10 hold", statusOut, fullStatus(3'b001));

    // R1: reset taken while flags are pending
    sctlCur = 32'h0000_0700;
    expiredPulse = 3'b111;
    @(posedge clk); #1;
    expiredPulse = '0;
    check("R7 all set", statusOut, 32'h8000_0067);
    rstN = 1'b0;
    #1;
    check("R1 reset mid-run status", statusOut, 32'h0000_0060);
    check("R1 reset mid-run irq", {31'd0, irqOut}, 32'd0);
    @(posedge clk); #1;
    rstN = 1'b1;
    @(posedge clk); #1;
    check("R9 after reset", statusOut, 32'h0000_0060);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule